// File: doc/BRIEF.md
# Row-Sequential Pixel Matrix Controller

This block drives a pixel matrix one row at a time. For the row it has selected it raises that row's gate line and then goes through a fixed sequence. First it strobes the column readout to take a sample of signal plus pedestal. Next it pulses the same row's clear line. Then it strobes a second sample, which holds pedestal only. After that it moves to the next row. The column electronics subtract the two samples. Only one row is powered at any moment.

Every phase length is a register value counted in clock cycles. The controller is built to run at up to 80 MHz, and it holds the clear pulse to as few cycles as the clear phase is given. A frame starts with a start pulse. When the last row has been served, a frame-done pulse is issued and the row counter wraps to zero. The controller then either goes idle or starts the next frame, as chosen by the continuous-mode input. A synchronous abort puts the block back into idle from any phase.

Top module: `rowseq_ctrl`

## Requirements
- R1: While reset is asserted, and up to the first start, every gate and clear output, both sample strobes, `frame_start`, `frame_done` and `busy` are low, and `row_idx` is 0.
- R2: While `busy` is high, `gate_en` has exactly the bit at `row_idx` set. While idle, `gate_en` is zero.
- R3: Each row goes through settle, first sample, clear, post-clear settle and second sample, in that order. Each phase lasts its programmed number of cycles (settle `t_settle`, both samples `t_sample`, clear `t_clear`, post `t_post`). A programmed value of 0 is treated as 1.
- R4: `clear_en` has only the current row's bit set, and only during the clear phase. It is never high together with a sample strobe.
- R5: `sample_sig` is high exactly in the first-sample phase and `sample_ped` is high exactly in the second-sample phase. The two are never high together.
- R6: Rows are served in the order 0, 1, ..., NUM_ROWS-1. `frame_start` is high for exactly the first cycle of row 0 in each frame.
- R7: `frame_done` is high for one cycle, in the cycle after the last second-sample cycle of the last row. With `continuous` low in that last cycle, the block goes idle (`busy` low, all outputs low).
- R8: With `continuous` high in the last cycle of a frame, the next cycle begins row 0 of a new frame, with `frame_done` and `frame_start` both high.
- R9: `abort` high at a clock edge makes the next cycle idle, with all gate, clear and strobe outputs low and `row_idx` 0. No `frame_done` is issued. Abort takes priority over `start`.
- R10: A `start` that arrives while `busy` is high has no effect. The timing inputs are captured only when a frame is started from idle, so changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a frame when idle |
| abort | input | 1 | Synchronous return to idle |
| continuous | input | 1 | Run the next frame immediately after the last row |
| t_settle | input | TW (8) | Gate settle cycles before the first sample |
| t_sample | input | TW (8) | Cycles of each sample strobe |
| t_clear | input | TW (8) | Clear pulse cycles |
| t_post | input | TW (8) | Settle cycles after clear |
| gate_en | output | NUM_ROWS (64) | Per-row gate select, one-hot while busy |
| clear_en | output | NUM_ROWS (64) | Per-row clear drive |
| sample_sig | output | 1 | First sample strobe (signal plus pedestal) |
| sample_ped | output | 1 | Second sample strobe (pedestal only) |
| row_idx | output | RW (6) | Row being served |
| frame_start | output | 1 | First cycle of a frame |
| frame_done | output | 1 | Frame completed pulse |
| busy | output | 1 | Sequencing in progress |

## Verification
A start sampled at one clock edge shows up as row 0 settle in the very next cycle. From there each phase occupies exactly its programmed count, so the bench advances through a model of the frame one cycle at a time and compares every output against that model at each falling edge. The frame-done pulse and the idle or wrapped state come one cycle after the final second-sample cycle. An abort shows its effect in the cycle right after the edge that samples it. The bench checks each of these in exactly that cycle and not in a later one.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_SAMP1  = 3'd2,
    PH_CLEAR  = 3'd3,
    PH_POST   = 3'd4,
    PH_SAMP2  = 3'd5
  } phase_t;
endpackage

// File: rtl/rowseq_rst_sync.sv
module rowseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_s_n = sync_q;
endmodule

// File: rtl/rowseq_timer.sv
module rowseq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_s_n,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] len,
  output logic          last
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  assign last = (cnt_q == (len - 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (en)  cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rowseq_onehot.sv
module rowseq_onehot #(
  parameter int N  = 64,
  parameter int RW = 6
) (
  input  logic          en,
  input  logic [RW-1:0] idx,
  output logic [N-1:0]  oh
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign oh[i] = en && (idx == RW'(i));
  end
endmodule

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS = 64,
  parameter int TW       = 8,
  localparam int RW      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  logic                continuous,
  input  logic [TW-1:0]       t_settle,
  input  logic [TW-1:0]       t_sample,
  input  logic [TW-1:0]       t_clear,
  input  logic [TW-1:0]       t_post,
  output logic [NUM_ROWS-1:0] gate_en,
  output logic [NUM_ROWS-1:0] clear_en,
  output logic                sample_sig,
  output logic                sample_ped,
  output logic [RW-1:0]       row_idx,
  output logic                frame_start,
  output logic                frame_done,
  output logic                busy
);
  localparam logic [RW-1:0] LAST_ROW = RW'(NUM_ROWS - 1);

  logic          rst_s_n;
  phase_t        ph_q, ph_d;
  logic [RW-1:0] row_q, row_d;
  logic          done_q, done_d;
  logic          fs_q, fs_d;
  logic          cfg_ld;
  logic [TW-1:0] cs_q, cp_q, cc_q, cq_q;
  logic [TW-1:0] len_sel;
  logic          ph_last;
  logic          active;

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  rowseq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  always_comb begin
    unique case (ph_q)
      PH_SETTLE:          len_sel = cs_q;
      PH_SAMP1, PH_SAMP2: len_sel = cp_q;
      PH_CLEAR:           len_sel = cc_q;
      PH_POST:            len_sel = cq_q;
      default:            len_sel = TW'(1);
    endcase
  end

  rowseq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_s_n(rst_s_n),
    .clr(!active || abort), .en(active),
    .len(len_sel), .last(ph_last)
  );

  always_comb begin
    ph_d   = ph_q;
    row_d  = row_q;
    done_d = 1'b0;
    fs_d   = 1'b0;
    cfg_ld = 1'b0;
    if (abort) begin
      ph_d  = PH_IDLE;
      row_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) begin
          ph_d   = PH_SETTLE;
          row_d  = '0;
          cfg_ld = 1'b1;
          fs_d   = 1'b1;
        end
        PH_SETTLE: if (ph_last) ph_d = PH_SAMP1;
        PH_SAMP1:  if (ph_last) ph_d = PH_CLEAR;
        PH_CLEAR:  if (ph_last) ph_d = PH_POST;
        PH_POST:   if (ph_last) ph_d = PH_SAMP2;
        PH_SAMP2: if (ph_last) begin
          if (row_q == LAST_ROW) begin
            row_d  = '0;
            done_d = 1'b1;
            ph_d   = continuous ? PH_SETTLE : PH_IDLE;
            fs_d   = continuous;
          end else begin
            row_d = row_q + 1'b1;
            ph_d  = PH_SETTLE;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q   <= PH_IDLE;
      row_q  <= '0;
      done_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      row_q  <= row_d;
      done_q <= done_d;
      fs_q   <= fs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cs_q <= TW'(1);
      cp_q <= TW'(1);
      cc_q <= TW'(1);
      cq_q <= TW'(1);
    end else if (cfg_ld) begin
      cs_q <= at_least_one(t_settle);
      cp_q <= at_least_one(t_sample);
      cc_q <= at_least_one(t_clear);
      cq_q <= at_least_one(t_post);
    end
  end

  assign active = (ph_q != PH_IDLE);

  rowseq_onehot #(.N(NUM_ROWS), .RW(RW)) u_gate_dec (
    .en(active), .idx(row_q), .oh(gate_en)
  );
  rowseq_onehot #(.N(NUM_ROWS), .RW(RW)) u_clr_dec (
    .en(ph_q == PH_CLEAR), .idx(row_q), .oh(clear_en)
  );

  assign sample_sig  = (ph_q == PH_SAMP1);
  assign sample_ped  = (ph_q == PH_SAMP2);
  assign row_idx     = row_q;
  assign frame_start = fs_q;
  assign frame_done  = done_q;
  assign busy        = active;
endmodule

// File: rtl/rowseq_ctrl_chk.sv
module rowseq_ctrl_chk #(
  parameter int NUM_ROWS = 64,
  parameter int RW       = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                abort,
  input logic [NUM_ROWS-1:0] gate_en,
  input logic [NUM_ROWS-1:0] clear_en,
  input logic                sample_sig,
  input logic                sample_ped,
  input logic [RW-1:0]       row_idx,
  input logic                frame_done,
  input logic                busy
);
  a_r2_gate_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_en) && (busy == (gate_en != '0)));

  a_r4_clear_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_en & ~gate_en) == '0);

  a_r4_clear_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_en != '0) |-> (!sample_sig && !sample_ped));

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_sig && sample_ped));

  a_r6_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_idx) < NUM_ROWS);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r7_done_after_ped: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(sample_ped));

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && gate_en == '0 && clear_en == '0 && !frame_done));
endmodule

bind rowseq_ctrl rowseq_ctrl_chk #(.NUM_ROWS(NUM_ROWS), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort),
  .gate_en(gate_en), .clear_en(clear_en),
  .sample_sig(sample_sig), .sample_ped(sample_ped),
  .row_idx(row_idx), .frame_done(frame_done), .busy(busy)
);

// File: tb/tb_rowseq_ctrl.sv
`timescale 1ns/1ps
module tb_rowseq_ctrl;
  localparam int N  = 8;
  localparam int TW = 4;
  localparam int RW = 3;

  logic clk, rst_n, start, abort, continuous;
  logic [TW-1:0] t_settle, t_sample, t_clear, t_post;
  logic [N-1:0] gate_en, clear_en;
  logic sample_sig, sample_ped, frame_start, frame_done, busy;
  logic [RW-1:0] row_idx;

  int errors = 0;
  int checks = 0;
  bit reported = 0;

  // settle, sample, clear, post
  localparam int VEC [4][4] = '{
    '{1, 1, 1, 1},
    '{2, 3, 1, 2},
    '{0, 2, 0, 1},
    '{3, 1, 2, 0}
  };

  rowseq_ctrl #(.NUM_ROWS(N), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .continuous(continuous), .t_settle(t_settle), .t_sample(t_sample),
    .t_clear(t_clear), .t_post(t_post), .gate_en(gate_en),
    .clear_en(clear_en), .sample_sig(sample_sig), .sample_ped(sample_ped),
    .row_idx(row_idx), .frame_start(frame_start), .frame_done(frame_done),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check_idle(input string req);
    chk(gate_en == '0 && clear_en == '0 && !sample_sig && !sample_ped && !busy && row_idx == 0,
        req, {gate_en, clear_en, sample_sig, sample_ped, busy}, 0);
  endtask

  // Called at the negedge of the first frame cycle; returns at the negedge after the last.
  task automatic run_frame(input int s, input int p, input int c, input int q, input bit done_first);
    int len [5];
    bit first = 1;
    len[0] = clamp1(s); len[1] = clamp1(p); len[2] = clamp1(c);
    len[3] = clamp1(q); len[4] = clamp1(p);
    for (int r = 0; r < N; r++) begin
      for (int ph = 0; ph < 5; ph++) begin
        for (int k = 0; k < len[ph]; k++) begin
          logic [N-1:0] eg, ec;
          logic [1:0] es;
          eg = N'(1) << r;
          ec = (ph == 2) ? eg : '0;
          es = (ph == 1) ? 2'b10 : (ph == 4) ? 2'b01 : 2'b00;
          chk(gate_en == eg && busy, "R2 gate one-hot", gate_en, eg);
          chk(clear_en == ec, "R4 clear", clear_en, ec);
          chk({sample_sig, sample_ped} == es, "R3/R5 phase strobes", {sample_sig, sample_ped}, es);
          chk(int'(row_idx) == r, "R6 row order", row_idx, r);
          chk(frame_start == (r == 0 && ph == 0 && k == 0), "R6 frame_start", frame_start, (r == 0 && ph == 0 && k == 0));
          chk(frame_done == (first && done_first), "R7 frame_done timing", frame_done, (first && done_first));
          first = 0;
          @(negedge clk);
        end
      end
    end
  endtask

  task automatic set_t(input int s, input int p, input int c, input int q);
    t_settle = TW'(s); t_sample = TW'(p); t_clear = TW'(c); t_post = TW'(q);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst_n = 0; start = 0; abort = 0; continuous = 0;
    set_t(1, 1, 1, 1);
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    chk(!frame_start && !frame_done, "R1 reset flags", {frame_start, frame_done}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_idle("R1 idle after reset release");

    // Table-driven single frames
    foreach (VEC[i]) begin
      set_t(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      pulse_start();
      run_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 0);
      chk(frame_done, "R7 done after last row", frame_done, 1);
      check_idle("R7 idle after single frame");
      @(negedge clk);
      chk(!frame_done, "R7 done is one cycle", frame_done, 0);
      check_idle("R7 stays idle");
    end

    // R10: start and timing changes mid-frame are ignored
    set_t(2, 1, 1, 1);
    pulse_start();
    fork
      run_frame(2, 1, 1, 1, 0);
      begin
        repeat (5) @(negedge clk);
        start = 1'b1; set_t(5, 4, 3, 2);
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(frame_done, "R10 frame unaffected by mid-frame start", frame_done, 1);
    check_idle("R10 no restart after ignored start");

    // R8: continuous mode, two frames then stop
    set_t(1, 2, 1, 1);
    continuous = 1'b1;
    pulse_start();
    run_frame(1, 2, 1, 1, 0);
    chk(frame_done && frame_start && busy, "R8 wrap into next frame", {frame_done, frame_start, busy}, 3'b111);
    fork
      run_frame(1, 2, 1, 1, 1);
      begin @(negedge clk); continuous = 1'b0; end
    join
    chk(frame_done && !frame_start, "R8 stop after continuous cleared", {frame_done, frame_start}, 2'b10);
    check_idle("R8 idle after last continuous frame");

    // R9: abort mid-frame
    set_t(1, 1, 2, 1);
    pulse_start();
    repeat (8) @(negedge clk);
    chk(busy, "R9 busy before abort", busy, 1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check_idle("R9 idle after abort");
    chk(!frame_done, "R9 no done on abort", frame_done, 0);
    // abort during clear phase
    set_t(1, 1, 3, 1);
    pulse_start();
    @(negedge clk); @(negedge clk);
    chk(clear_en == N'(1), "R4 clear active row 0", clear_en, 1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(clear_en == '0, "R9 clear dropped by abort", clear_en, 0);
    // abort wins over start
    start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    check_idle("R9 abort priority over start");
    @(negedge clk);
    check_idle("R9 still idle");

    // Async reset in mid-frame
    pulse_start();
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1 reset mid-frame");
    rst_n = 1'b1;

    summary();
    $finish;
  end
endmodule